// File: doc/BRIEF.md
# Pipelined CORDIC Phase Extractor

This block turns a complex baseband sample into its phase angle, the quantity a receiver differentiates or slices for phase and frequency demodulation. Each clock it may take one signed in-phase word (I, the cosine part) and one signed quadrature word (Q, the sine part), tagged by a valid strobe. It returns the signed angle atan2(Q, I) in radians, scaled by 2^16, with its own valid strobe a fixed number of cycles later.

The angle is found by vectoring-mode CORDIC. A chain of shift-and-add micro-rotations drives the Y component toward zero and sums the elementary angles used on the way. The iteration only converges for vectors in the right half-plane. A front register therefore mirrors left half-plane samples through the origin and flags them, and a final register moves the accumulated angle by half a turn for flagged samples. The vector gain of the chain scales X only, so the angle needs no gain correction.

Top module: `phase_cordic_pipe`

## Requirements
- R1: Every sample with `in_valid` high yields exactly one `out_valid` pulse 18 clock cycles later (1 fold register, 16 rotation registers, 1 correction register). A new sample is accepted on every clock, with no stall.
- R2: While `rst_n` is low, which acts asynchronously, `out_valid` and `out_angle` are 0, and samples already in flight are discarded.
- R3: `out_angle` is a two's complement angle in radians scaled by 2^16, positive counter-clockwise from +I. For I >= 0 and max(|I|,|Q|) >= 2^16, it lies within 24 LSB of atan2(Q, I)*2^16.
- R4: For I < 0, the result lies in the second or third quadrant. It is within 24 LSB of atan2(Q, I)*2^16, with the distance taken modulo one full turn (411775 LSB).
- R5: Every valid `out_angle` lies in the range -205887 to +205887 (±pi).
- R6: Samples on the axes give 0, +102944, -102944 and ±205887 (0, pi/2, -pi/2, pi) within the R3/R4 tolerance.
- R7: Full-scale inputs, including -2^31 on either component, do not overflow the internal X path, and the result still meets R3/R4.
- R8: A cycle with `in_valid` low produces no output pulse, whatever `in_i` and `in_q` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 32 | In-phase component, signed |
| in_q | input | 32 | Quadrature component, signed |
| out_valid | output | 1 | Result strobe |
| out_angle | output | 32 | Phase, signed radians x 2^16 |

## Verification
The overflow and range assertions assume that a valid input is never the zero vector and that I and Q stay within 32-bit two's complement. Full-scale corners are legal. The stimulus never sends (0, 0) as a valid sample. Its accuracy vectors use amplitudes of at least 2^16, and separate full-scale vectors reach the edges of the signed range. Invalid cycles carry arbitrary nonzero data on purpose, so that anything leaking through them shows up at the output.

// File: rtl/phase_cordic_pkg.sv
package phase_cordic_pkg;

    // Angle scale: radians times 2^16
    localparam int ANG_FRAC  = 16;
    localparam int PI_Q16    = 205887;
    localparam int HALF_TURN = PI_Q16;

    // floor(atan(2^-idx) * 2^16); zero beyond the resolution of the scale
    function automatic int atan_q16(input int idx);
        case (idx)
            0:  return 51471;
            1:  return 30385;
            2:  return 16054;
            3:  return 8149;
            4:  return 4090;
            5:  return 2047;
            6:  return 1023;
            7:  return 511;
            8:  return 255;
            9:  return 127;
            10: return 63;
            11: return 31;
            12: return 15;
            13: return 7;
            14: return 3;
            15: return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/phase_cordic_fold.sv
module phase_cordic_fold #(
    parameter int IN_W = 32,
    parameter int W    = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_vld,
    input  logic [IN_W-1:0]     i_re,
    input  logic [IN_W-1:0]     i_im,
    output logic                o_vld,
    output logic                o_flip,
    output logic signed [W-1:0] o_x,
    output logic signed [W-1:0] o_y
);
    localparam int EXT_W = W - IN_W;

    typedef struct packed {
        logic         vld;
        logic         flip;
        logic [W-1:0] x;
        logic [W-1:0] y;
    } fold_t;

    fold_t fold_d, fold_q;
    logic signed [W-1:0] re_ext, im_ext;

    always_comb begin
        re_ext = {{EXT_W{i_re[IN_W-1]}}, i_re};
        im_ext = {{EXT_W{i_im[IN_W-1]}}, i_im};
        fold_d.vld  = i_vld;
        fold_d.flip = re_ext[W-1];
        if (re_ext[W-1]) begin
            fold_d.x = -re_ext;
            fold_d.y = -im_ext;
        end else begin
            fold_d.x = re_ext;
            fold_d.y = im_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fold_q <= '0;
        else        fold_q <= fold_d;
    end

    assign o_vld  = fold_q.vld;
    assign o_flip = fold_q.flip;
    assign o_x    = fold_q.x;
    assign o_y    = fold_q.y;

    AST_FOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> !o_x[W-1]); // R4

endmodule

// File: rtl/phase_cordic_stage.sv
module phase_cordic_stage #(
    parameter int W     = 48,
    parameter int ANG_W = 32,
    parameter int SHIFT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_vld,
    input  logic                    i_flip,
    input  logic signed [W-1:0]     i_x,
    input  logic signed [W-1:0]     i_y,
    input  logic signed [ANG_W-1:0] i_z,
    output logic                    o_vld,
    output logic                    o_flip,
    output logic signed [W-1:0]     o_x,
    output logic signed [W-1:0]     o_y,
    output logic signed [ANG_W-1:0] o_z
);
    localparam logic signed [ANG_W-1:0] STEP =
        ANG_W'(phase_cordic_pkg::atan_q16(SHIFT));

    typedef struct packed {
        logic             vld;
        logic             flip;
        logic [W-1:0]     x;
        logic [W-1:0]     y;
        logic [ANG_W-1:0] z;
    } rot_t;

    rot_t rot_d, rot_q;
    logic signed [W-1:0] x_sh, y_sh;

    always_comb begin
        x_sh = i_x >>> SHIFT;
        y_sh = i_y >>> SHIFT;
        rot_d.vld  = i_vld;
        rot_d.flip = i_flip;
        if (!i_y[W-1]) begin
            // Y non-negative: turn clockwise, angle accumulates upward
            rot_d.x = i_x + y_sh;
            rot_d.y = i_y - x_sh;
            rot_d.z = i_z + STEP;
        end else begin
            rot_d.x = i_x - y_sh;
            rot_d.y = i_y + x_sh;
            rot_d.z = i_z - STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rot_q <= '0;
        else        rot_q <= rot_d;
    end

    assign o_vld  = rot_q.vld;
    assign o_flip = rot_q.flip;
    assign o_x    = rot_q.x;
    assign o_y    = rot_q.y;
    assign o_z    = rot_q.z;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && !i_x[W-1]) |=> !o_x[W-1]); // R7

endmodule

// File: rtl/phase_cordic_fix.sv
module phase_cordic_fix #(
    parameter int ANG_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_vld,
    input  logic                    i_flip,
    input  logic signed [ANG_W-1:0] i_z,
    output logic                    o_vld,
    output logic signed [ANG_W-1:0] o_ang
);
    localparam logic signed [ANG_W-1:0] PI_A = ANG_W'(phase_cordic_pkg::HALF_TURN);

    typedef struct packed {
        logic             vld;
        logic [ANG_W-1:0] ang;
    } fix_t;

    fix_t fix_d, fix_q;

    always_comb begin
        fix_d.vld = i_vld;
        if (!i_flip)         fix_d.ang = i_z;
        else if (i_z[ANG_W-1]) fix_d.ang = i_z + PI_A;
        else                 fix_d.ang = i_z - PI_A;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fix_q <= '0;
        else        fix_q <= fix_d;
    end

    assign o_vld = fix_q.vld;
    assign o_ang = fix_q.ang;

    AST_ANGLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (o_ang >= -PI_A && o_ang <= PI_A)); // R5

endmodule

// File: rtl/phase_cordic_pipe.sv
module phase_cordic_pipe #(
    parameter int IN_W    = 32,
    parameter int GUARD_W = 16,
    parameter int ITERS   = 16,
    parameter int ANG_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_i,
    input  logic [IN_W-1:0]         in_q,
    output logic                    out_valid,
    output logic signed [ANG_W-1:0] out_angle
);
    localparam int W       = IN_W + GUARD_W;
    localparam int LATENCY = ITERS + 2;
    localparam int CNT_W   = $clog2(LATENCY + 1) + 1;

    logic                    c_vld  [ITERS+1];
    logic                    c_flip [ITERS+1];
    logic signed [W-1:0]     c_x    [ITERS+1];
    logic signed [W-1:0]     c_y    [ITERS+1];
    logic signed [ANG_W-1:0] c_z    [ITERS+1];

    phase_cordic_fold #(.IN_W(IN_W), .W(W)) fold_i (
        .clk(clk), .rst_n(rst_n), .i_vld(in_valid), .i_re(in_i), .i_im(in_q),
        .o_vld(c_vld[0]), .o_flip(c_flip[0]), .o_x(c_x[0]), .o_y(c_y[0])
    );
    assign c_z[0] = '0;

    for (genvar s = 0; s < ITERS; s++) begin : g_rot
        phase_cordic_stage #(.W(W), .ANG_W(ANG_W), .SHIFT(s)) stage_i (
            .clk(clk), .rst_n(rst_n),
            .i_vld(c_vld[s]), .i_flip(c_flip[s]), .i_x(c_x[s]), .i_y(c_y[s]), .i_z(c_z[s]),
            .o_vld(c_vld[s+1]), .o_flip(c_flip[s+1]), .o_x(c_x[s+1]), .o_y(c_y[s+1]),
            .o_z(c_z[s+1])
        );
    end

    phase_cordic_fix #(.ANG_W(ANG_W)) fix_i (
        .clk(clk), .rst_n(rst_n), .i_vld(c_vld[ITERS]), .i_flip(c_flip[ITERS]),
        .i_z(c_z[ITERS]), .o_vld(out_valid), .o_ang(out_angle)
    );

    // In-flight sample count, used only by the checks below
    logic [CNT_W-1:0] fly_d, fly_q;
    always_comb fly_d = fly_q + CNT_W'(in_valid) - CNT_W'(out_valid);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fly_q <= '0;
        else        fly_q <= fly_d;
    end

    AST_INFLIGHT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fly_q <= CNT_W'(LATENCY)); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fly_q != '0); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_angle == '0)); // R2

endmodule

// File: tb/phase_cordic_pipe_tb_top.sv
module phase_cordic_pipe_tb_top;
    localparam int  CLK_NS = 8;
    localparam int  LAT    = 18;
    localparam real TOL    = 24.0;
    localparam real PI_Q   = 205887.0;
    localparam real TURN_Q = 411775.0;
    localparam int  A      = 1048576;
    localparam int  NV     = 20;
    localparam int  VI [NV] = '{ A, 0, 0, -A, A, A, -A, -A, 908093, -524288,
                                 200000, -640000, -640000, -640000, 2147483647,
                                 -2147483647-1, -2147483647-1, 2147483647, 65536, -70000 };
    localparam int  VQ [NV] = '{ 0, A, -A, 0, A, -A, A, -A, 524288, 908093,
                                 -777777, -48000, 1, -1, 2147483647,
                                 -2147483647-1, 2147483647, -5, 113512, 30000 };

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic in_valid = 1'b0;
    logic [31:0] in_i = '0;
    logic [31:0] in_q = '0;
    logic out_valid;
    logic signed [31:0] out_angle;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_sent = 0;
    int n_recv = 0;
    real   exp_ang [64];
    int    drv_cyc [64];
    string exp_req [64];

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_cordic_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_angle(out_angle)
    );

    function automatic real turn_dist(input real got, input real want);
        real d;
        d = got - want;
        if (d > PI_Q)  d = d - TURN_Q;
        if (d < -PI_Q) d = d + TURN_Q;
        return (d < 0.0) ? -d : d;
    endfunction

    function automatic string req_of(input int k);
        if (k < 4)  return "R6";
        if (k >= 14 && k < 18) return "R7";
        return (VI[k] < 0) ? "R4" : "R3";
    endfunction

    // Output monitor: accuracy (R3/R4/R6/R7), latency (R1), no extra pulses (R8)
    always @(negedge clk) begin
        if (out_valid) begin
            if (n_recv >= n_sent) begin
                checks++; fails++;
                $display("FAIL R8 unexpected out_valid: got 1 expected 0 (angle %0d)", out_angle);
            end else begin
                checks += 2;
                if (turn_dist(real'(out_angle), exp_ang[n_recv % 64]) > TOL) begin
                    fails++;
                    $display("FAIL %s sample %0d angle: got %0d expected %0.1f",
                             exp_req[n_recv % 64], n_recv, out_angle, exp_ang[n_recv % 64]);
                end
                if (cyc != drv_cyc[n_recv % 64] + LAT) begin
                    fails++;
                    $display("FAIL R1 sample %0d latency: got %0d expected %0d",
                             n_recv, cyc - drv_cyc[n_recv % 64], LAT);
                end
                n_recv++;
            end
        end
    end

    task automatic send(input int i, input int q, input bit v, input string rq);
        @(negedge clk);
        in_valid = v;
        in_i = i;
        in_q = q;
        if (v) begin
            exp_ang[n_sent % 64] = $atan2(real'(q), real'(i)) * 65536.0;
            drv_cyc[n_sent % 64] = cyc;
            exp_req[n_sent % 64] = rq;
            n_sent++;
        end
    endtask

    task automatic drain();
        send(0, 0, 1'b0, "");
        repeat (LAT + 4) @(negedge clk);
    endtask

    task automatic check_count(input string rq);
        checks++;
        if (n_recv != n_sent) begin
            fails++;
            $display("FAIL %s result count: got %0d expected %0d", rq, n_recv, n_sent);
        end
    endtask

    task automatic check_reset_outputs();
        checks++;
        if (out_valid !== 1'b0 || out_angle !== 32'sd0) begin
            fails++;
            $display("FAIL R2 outputs in reset: got %0b/%0d expected 0/0", out_valid, out_angle);
        end
    endtask

    initial begin
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_outputs();                       // R2 reset state
        rst_n = 1'b1;

        // Back-to-back vector stream: R1 throughput, R3 R4 R6 R7 accuracy
        for (int k = 0; k < NV; k++) send(VI[k], VQ[k], 1'b1, req_of(k));
        drain();
        check_count("R1");

        // Bubbles carrying junk data must not produce results: R8
        send(A, 0, 1'b1, "R8");
        send(12345, 678, 1'b0, "");
        send(0, A, 1'b1, "R8");
        send(777, -999, 1'b0, "");
        send(-9, -4444, 1'b0, "");
        send(A, A, 1'b1, "R8");
        drain();
        check_count("R8");

        // Reset with samples in flight: R2 discards them
        for (int k = 0; k < 6; k++) send(VI[k + 4], VQ[k + 4], 1'b1, "R2");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_outputs();
        n_sent = n_recv;
        rst_n = 1'b1;
        repeat (LAT + 6) @(negedge clk);
        check_count("R2");

        // After reset the pipeline still works: R1 R4
        send(-A, A, 1'b1, "R4");
        send(0, -A, 1'b1, "R6");
        drain();
        check_count("R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule